// File: doc/BRIEF.md
# I2C Serial Clock Generator with Prescaler

This block produces the serial clock of an I2C master. The system clock is first divided by a programmable prescale value to give a slower internal tick. The SCL waveform is then built from a low phase and a high phase. Each phase lasts its programmed count plus a fixed overhead of 5, 6 or 7 ticks, and the prescale value selects which overhead applies. A build parameter can instead fix the overhead at 6 for an alternate controller flavour. The block drives the line open-drain style: it either pulls SCL low or releases it. It also reads the real line level, so a slave that holds SCL low stretches the high phase.

All three divider values are captured while the block is held, which happens when the hold input is set or the run enable is clear. On release the captured copies alone set the timing. Writes to the inputs while the block runs have no effect until the next hold. A high count of zero suppresses the clock entirely. A one-cycle strobe marks the middle of every high phase so that the bit engine can sample SDA.

States: `PH_IDLE` (held, line released), `PH_LOW` (pulling SCL low), `PH_HIGH` (line released, counting while sensed high), `PH_HALT` (high count zero, line released forever). Transitions: any state → `PH_IDLE` while held. `PH_IDLE` → `PH_LOW` on release when the high count is non-zero, otherwise `PH_IDLE` → `PH_HALT`. `PH_LOW` → `PH_HIGH` on the last tick of the low phase. `PH_HIGH` → `PH_LOW` on the last counted tick of the high phase.

Top module: `scl_clock_gen`

## Requirements
- R1: While `core_hold` is 1 or `run_en` is 0, `scl_pull_low` is 0 and `sda_sample_stb` is 0 from the next cycle on.
- R2: One internal tick occurs every `presc_val`+1 system clocks, and all phase lengths are whole multiples of that.
- R3: In steady state a low phase (`scl_pull_low`=1) lasts (`low_val`+d)·(`presc_val`+1) system clocks.
- R4: In steady state, with no stretching, a high phase lasts (`high_val`+d)·(`presc_val`+1) system clocks.
- R5: With the default build, the overhead d is 7 for a prescale of 0, 6 for a prescale of 1 and 5 for 2 or more.
- R6: With `FIXED_OVH`=1, d is 6 for every prescale value.
- R7: If the captured high count is 0, `scl_pull_low` stays 0 and no strobe occurs for as long as the block runs.
- R8: Ticks that arrive while `scl_in` is 0 during a high phase are not counted, so m skipped ticks lengthen the high phase by m·(`presc_val`+1) clocks.
- R9: `sda_sample_stb` pulses for exactly one cycle per high phase. It occurs on the counted tick whose index equals floor((`high_val`+d)/2), counting from 0, which is cycle ((floor((high+d)/2))+1+m)·(psc+1)−1 of the phase.
- R10: Changes to `presc_val`, `low_val` and `high_val` while the block runs are ignored until the next hold.
- R11: In the cycle after release, `scl_pull_low` is 1 when the high count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; 0 holds the generator |
| core_hold | input | 1 | Module hold; 1 holds the generator and loads divider values |
| presc_val | input | DIV_W | Prescale value (divide by value+1) |
| low_val | input | DIV_W | Low phase count before overhead |
| high_val | input | DIV_W | High phase count before overhead; 0 disables SCL |
| scl_in | input | 1 | Sensed SCL line level |
| scl_pull_low | output | 1 | 1 = pull SCL low, 0 = release |
| sda_sample_stb | output | 1 | One-cycle mid-high-phase strobe |

## Verification
Clock stretching and the midpoint strobe can fall into the same high phase. The bench provokes this by holding the modelled line low for a whole number of ticks right after the release. It then checks that the strobe moves later by exactly the skipped ticks and still fires once. The last tick of a phase and the prescaler wrap always coincide. The bench sweeps prescale, low and high counts and compares each measured low length, high length and strobe offset with arithmetic formulas. During every run it also loads garbage onto the inputs, which must not disturb the timing.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_HALT = 2'd3
    } phase_e;
endpackage

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [DIV_W-1:0] psc,
    output logic             tick
);
    logic [DIV_W-1:0] pcnt;

    assign tick = !hold && (pcnt == psc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pcnt <= '0;
        else if (hold)       pcnt <= '0;
        else if (pcnt == psc) pcnt <= '0;
        else                 pcnt <= pcnt + 1'b1;
    end

    // R2: a tick is never followed by another tick unless the divisor is 1
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psc != '0 && !hold) |=> !tick);
endmodule

// File: rtl/scl_ovh_sel.sv
module scl_ovh_sel #(
    parameter int DIV_W     = 16,
    parameter bit FIXED_OVH = 1'b0
) (
    input  logic [DIV_W-1:0] psc,
    output logic [3:0]       ovh
);
    logic [3:0] by_psc;

    always_comb begin
        if (psc == '0)                 by_psc = 4'd7;
        else if (psc == DIV_W'(1))     by_psc = 4'd6;
        else                           by_psc = 4'd5;
    end

    assign ovh = FIXED_OVH ? 4'd6 : by_psc;
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             tick,
    input  logic             scl_in,
    input  logic [DIV_W-1:0] low_sh,
    input  logic [DIV_W-1:0] high_sh,
    input  logic [3:0]       ovh,
    output logic             scl_pull_low,
    output logic             sda_sample_stb
);
    localparam int CW = DIV_W + 1;

    phase_e         st, st_nx;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  low_lim, high_lim, half;
    logic           adv;

    assign low_lim  = CW'(low_sh)  + CW'(ovh);
    assign high_lim = CW'(high_sh) + CW'(ovh);
    assign half     = high_lim >> 1;
    assign adv      = tick && ((st == PH_LOW) || (st == PH_HIGH && scl_in));

    always_comb begin
        st_nx = st;
        unique case (st)
            PH_IDLE: st_nx = (high_sh == '0) ? PH_HALT : PH_LOW;
            PH_LOW:  if (tick && cnt == low_lim - 1'b1) st_nx = PH_HIGH;
            PH_HIGH: if (tick && scl_in && cnt == high_lim - 1'b1) st_nx = PH_LOW;
            PH_HALT: st_nx = PH_HALT;
        endcase
        if (hold) st_nx = PH_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= PH_IDLE;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (hold || st_nx != st) cnt <= '0;
            else if (adv)            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        scl_pull_low   = (st == PH_LOW);
        sda_sample_stb = (st == PH_HIGH) && tick && scl_in && (cnt == half);
    end

    // R1: held generator releases the line and stays silent
    p_hold_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!scl_pull_low && !sda_sample_stb));
    // R3: low counter stays inside the low window
    p_low_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_LOW) |-> (cnt < low_lim));
    // R7: zero high count never pulls the line
    p_zero_high_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (high_sh == '0 && !hold && st != PH_IDLE) |-> !scl_pull_low);
    // R8: counter frozen while the line is held low in the high phase
    p_stretch_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_HIGH && !scl_in && !hold) |=> (cnt == $past(cnt)));
    // R9: strobe lasts a single cycle
    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample_stb |=> !sda_sample_stb);
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
    parameter int DIV_W     = 16,
    parameter bit FIXED_OVH = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             core_hold,
    input  logic [DIV_W-1:0] presc_val,
    input  logic [DIV_W-1:0] low_val,
    input  logic [DIV_W-1:0] high_val,
    input  logic             scl_in,
    output logic             scl_pull_low,
    output logic             sda_sample_stb
);
    logic             hold;
    logic             tick;
    logic [DIV_W-1:0] psc_sh, low_sh, high_sh;
    logic [3:0]       ovh;

    assign hold = core_hold || !run_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_sh  <= '0;
            low_sh  <= '0;
            high_sh <= '0;
        end else if (hold) begin
            psc_sh  <= presc_val;
            low_sh  <= low_val;
            high_sh <= high_val;
        end
    end

    scl_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .hold(hold), .psc(psc_sh), .tick(tick)
    );

    scl_ovh_sel #(.DIV_W(DIV_W), .FIXED_OVH(FIXED_OVH)) u_ovh (
        .psc(psc_sh), .ovh(ovh)
    );

    scl_phase_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hold(hold), .tick(tick), .scl_in(scl_in),
        .low_sh(low_sh), .high_sh(high_sh), .ovh(ovh),
        .scl_pull_low(scl_pull_low), .sda_sample_stb(sda_sample_stb)
    );

    // R10: captured values stay put while running
    p_frozen_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !$past(hold)) |-> $stable(low_sh) && $stable(high_sh) && $stable(psc_sh));
endmodule

// File: tb/tb_scl_clock_gen.sv
module tb_scl_clock_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b1;
    logic        core_hold = 1'b1;
    logic [15:0] presc_val = '0, low_val = '0, high_val = '0;
    logic        stretch = 1'b0;
    logic        drv_d, stb_d, drv_f, stb_f;
    logic        scl_d, scl_f;
    int          errors = 0, checks = 0, cyc = 0;

    always #5 clk = ~clk;

    assign scl_d = ~drv_d & ~stretch;
    assign scl_f = ~drv_f;

    scl_clock_gen dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .core_hold(core_hold),
        .presc_val(presc_val), .low_val(low_val), .high_val(high_val),
        .scl_in(scl_d), .scl_pull_low(drv_d), .sda_sample_stb(stb_d)
    );

    scl_clock_gen #(.FIXED_OVH(1'b1)) dut_fx (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .core_hold(core_hold),
        .presc_val(presc_val), .low_val(low_val), .high_val(high_val),
        .scl_in(scl_f), .scl_pull_low(drv_f), .sda_sample_stb(stb_f)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic drv(input int which);
        return which != 0 ? drv_f : drv_d;
    endfunction

    function automatic logic stb(input int which);
        return which != 0 ? stb_f : stb_d;
    endfunction

    task automatic load(input int p, input int l, input int h);
        @(negedge clk);
        core_hold = 1'b1;
        presc_val = 16'(p); low_val = 16'(l); high_val = 16'(h);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_cfg(input int p, input int l, input int h, input int m, input int which);
        int d, s, lo_len, hi_len, mid_off, mids, half;
        d = (which != 0) ? 6 : ((p == 0) ? 7 : ((p == 1) ? 6 : 5));
        s = m * (p + 1);
        half = (h + d) / 2;
        load(p, l, h);
        check(drv(which) == 1'b0 && stb(which) == 1'b0, "R1 held output", int'(drv(which)), 0);
        core_hold = 1'b0;
        @(negedge clk);
        check(drv(which) == 1'b1, "R11 low after release", int'(drv(which)), 1);
        // R10: garbage on the inputs while running
        presc_val = 16'd7; low_val = 16'd9; high_val = 16'd0;
        while (drv(which)) @(negedge clk);
        while (!drv(which)) @(negedge clk);
        lo_len = 0;
        while (drv(which)) begin lo_len++; @(negedge clk); end
        hi_len = 0; mids = 0; mid_off = -1;
        while (!drv(which)) begin
            if (hi_len == 0 && s > 0) stretch = 1'b1;
            if (hi_len == s) stretch = 1'b0;
            #1;
            if (stb(which)) begin mids++; mid_off = hi_len; end
            hi_len++;
            @(negedge clk);
        end
        stretch = 1'b0;
        check(lo_len == (l + d) * (p + 1),
              which != 0 ? "R6 R3 R10 low length" : "R5 R3 R2 R10 low length",
              lo_len, (l + d) * (p + 1));
        check(hi_len == (h + d + m) * (p + 1), "R4 R8 high length", hi_len, (h + d + m) * (p + 1));
        check(mids == 1, "R9 strobe count", mids, 1);
        check(mid_off == (half + 1 + m) * (p + 1) - 1, "R9 strobe offset",
              mid_off, (half + 1 + m) * (p + 1) - 1);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : main
        int lows[3];
        int highs[3];
        int quiet;
        lows = '{1, 2, 5};
        highs = '{1, 3, 4};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(drv_d == 1'b0 && stb_d == 1'b0, "R1 reset state", int'(drv_d), 0);

        for (int p = 0; p < 4; p++)
            for (int li = 0; li < 3; li++)
                for (int hi = 0; hi < 3; hi++)
                    run_cfg(p, lows[li], highs[hi], (highs[hi] == 3) ? 2 : 0, 0);

        for (int p = 0; p < 4; p++) run_cfg(p, 2, 3, 0, 1);

        // R7: zero high count
        load(1, 3, 0);
        core_hold = 1'b0;
        quiet = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (drv_d || stb_d) quiet++;
        end
        check(quiet == 0, "R7 zero high count silent", quiet, 0);

        // R1: run enable dropped mid-phase
        load(0, 4, 4);
        core_hold = 1'b0;
        while (!drv_d) @(negedge clk);
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(drv_d == 1'b0, "R1 enable low releases", int'(drv_d), 0);
        quiet = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (drv_d || stb_d) quiet++;
        end
        check(quiet == 0, "R1 enable low silent", quiet, 0);
        run_en = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule